// File: doc/BRIEF.md
# Video Link Receive Output Stage

This block is the last stage of the receive side of a serial video link. It runs on the recovered pixel clock and accepts one aligned 30-bit word per pixel from the word aligner. Each word carries three 10-bit symbols in the 8b/10b line code. The stage decodes all three symbols and checks them against the code table and the running disparity. From a clean word it rebuilds either a 24-bit RGB pixel with the data-enable raised, or a blanking word that updates the horizontal and vertical sync state.

The RGB bus keeps the last pixel through blanking. The sync pins follow two static polarity straps. A link-status flag reports whether clean coded data is arriving. The flag drops on any bad word and recovers only after a run of clean words.

Words enter on a valid/ready handshake. The stage never applies back-pressure. `in_ready` rises one clock after reset is released and then stays high. A word is taken on every rising edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low are bubbles and have no effect.

Top module: `vlink_rx_out`

## Requirements
- R1: While reset is asserted, and until the first word is decoded, `rgb_out` is 0, `de_out` is 0, `link_ok` is 0, both sync pins sit at their inactive level and `in_ready` is 0. `in_ready` is 1 from the first rising edge after reset is released and stays 1.
- R2: Word layout: bits [29:20] are lane 0, [19:10] are lane 1 and [9:0] are lane 2, and they map to `rgb_out[23:16]`, `[15:8]` and `[7:0]`. Running disparity passes from lane 0 to lane 1 to lane 2, then on to the next word. Within a symbol, bits [9:4] hold the 6-bit sub-block abcdei with a at bit 9, and bits [3:0] hold fghj with f at bit 3. The 6-bit sub-block decodes to byte bits [4:0] and the 4-bit sub-block to bits [7:5].
- R3: A word of three valid data symbols sets `de_out` to 1 and loads the three decoded bytes onto `rgb_out`.
- R4: A word of three control symbols K28.0 to K28.3 sets `de_out` to 0 and leaves `rgb_out` unchanged. The sync state comes from lane 0's K28.y: y bit 0 is hsync active and y bit 1 is vsync active. Data words leave the sync state unchanged.
- R5: Each sync pin equals its active flag XOR its strap: strap 1 means active low, strap 0 means active high.
- R6: A word is bad if any symbol has a sub-block outside the code table, if any symbol is a K28.y with y above 3, or if it mixes control and data symbols. A bad word changes none of `rgb_out`, `de_out` or the sync state.
- R7: Running disparity is negative after reset. A 6-bit sub-block with more ones than zeros, or the code 111000, needs negative disparity on entry. One with fewer ones than zeros, or 000111, needs positive disparity. The same rules apply to the 4-bit sub-block, with 1100 and 0011 as the special codes. A breach makes the word bad. After every sub-block, valid or not, disparity becomes positive if it had more ones or was 000111 or 0011. It becomes negative if it had fewer ones or was 111000 or 1100. Otherwise it is unchanged.
- R8: A bad word clears `link_ok`. `link_ok` becomes 1 only on the 4th consecutive clean word. Bubble cycles neither count toward that run nor break it.
- R9: Every output reflects an accepted word after the second rising edge, counting the accepting edge, and not after the first. With no accepted word, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Aligned word present |
| in_ready | output | 1 | Stage accepts words (high after reset) |
| in_word | input | 30 | Three 10-bit coded symbols, lane 0 in the top bits |
| hsync_pol | input | 1 | Horizontal sync strap, 1 = active low |
| vsync_pol | input | 1 | Vertical sync strap, 1 = active low |
| rgb_out | output | 24 | Pixel data, held through blanking |
| hsync_out | output | 1 | Horizontal sync pin |
| vsync_out | output | 1 | Vertical sync pin |
| de_out | output | 1 | Data enable |
| link_ok | output | 1 | Clean coded data is being received |

## Verification
The hardest case to reach is a disparity breach on a symbol that is itself in the code table. A correct encoder never produces one. The bench runs its own disparity tracker and deliberately encodes lane 0 in the form meant for the opposite disparity. It then keeps tracking through that forged symbol, so the recovery words that follow are encoded with the disparity the stage must now expect. The same tracker covers an all-ones garbage symbol, a K28.5 word and a mixed control/data word. Three clean words are then sent to show the status still low, and a fourth raises it.

// File: rtl/vlink_rx_pkg.sv
`timescale 1ns/1ps
package vlink_rx_pkg;

  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] val;   // {y[2:0], x[4:0]}
    logic              is_k;  // K28.y control symbol
    logic              bad;   // table or disparity breach
  } sym_res_t;

  // Disparity after the 6-bit sub-block (1 = positive)
  function automatic logic rd_after6(input logic [5:0] c, input logic rd);
    int n;
    n = $countones(c);
    if (n > 3 || c == 6'b000111)      return 1'b1;
    else if (n < 3 || c == 6'b111000) return 1'b0;
    else                              return rd;
  endfunction

  // Disparity after the 4-bit sub-block (1 = positive)
  function automatic logic rd_after4(input logic [3:0] c, input logic rd);
    int n;
    n = $countones(c);
    if (n > 2 || c == 4'b0011)      return 1'b1;
    else if (n < 2 || c == 4'b1100) return 1'b0;
    else                            return rd;
  endfunction

endpackage

// File: rtl/vlink_sym_dec.sv
`timescale 1ns/1ps
// One 10-bit symbol: table lookup, disparity check, next disparity.
module vlink_sym_dec
  import vlink_rx_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  input  logic             rd_in,
  output sym_res_t         res,
  output logic             rd_out
);

  logic [5:0] c6, cc6;
  logic [3:0] c4;
  logic [4:0] x;
  logic [2:0] y;
  logic       k, bad6, bad4, rd_mid;
  int         n6, n4;

  always_comb begin
    c6   = sym[9:4];
    c4   = sym[3:0];
    n6   = $countones(c6);
    n4   = $countones(c4);
    cc6  = c6;
    x    = '0;
    y    = '0;
    k    = 1'b0;
    bad6 = 1'b0;
    bad4 = 1'b0;

    // 6-bit sub-block (R6)
    if (n6 == 3) begin
      unique case (c6)
        6'b110001: x = 5'd3;
        6'b101001: x = 5'd5;
        6'b011001: x = 5'd6;
        6'b111000: x = 5'd7;
        6'b000111: x = 5'd7;
        6'b100101: x = 5'd9;
        6'b010101: x = 5'd10;
        6'b110100: x = 5'd11;
        6'b001101: x = 5'd12;
        6'b101100: x = 5'd13;
        6'b011100: x = 5'd14;
        6'b100011: x = 5'd17;
        6'b010011: x = 5'd18;
        6'b110010: x = 5'd19;
        6'b001011: x = 5'd20;
        6'b101010: x = 5'd21;
        6'b011010: x = 5'd22;
        6'b100110: x = 5'd25;
        6'b010110: x = 5'd26;
        6'b001110: x = 5'd28;
        default:   bad6 = 1'b1;
      endcase
    end else if (n6 == 2 || n6 == 4) begin
      // weight-2 codes are the complements of the weight-4 codes
      cc6 = (n6 == 4) ? c6 : ~c6;
      unique case (cc6)
        6'b100111: x = 5'd0;
        6'b011101: x = 5'd1;
        6'b101101: x = 5'd2;
        6'b110101: x = 5'd4;
        6'b111001: x = 5'd8;
        6'b010111: x = 5'd15;
        6'b011011: x = 5'd16;
        6'b111010: x = 5'd23;
        6'b110011: x = 5'd24;
        6'b110110: x = 5'd27;
        6'b101110: x = 5'd29;
        6'b011110: x = 5'd30;
        6'b101011: x = 5'd31;
        6'b001111: begin x = 5'd28; k = 1'b1; end
        default:   bad6 = 1'b1;
      endcase
    end else begin
      bad6 = 1'b1;
    end

    // 6-bit disparity rules (R7)
    if (n6 == 4 && rd_in)              bad6 = 1'b1;
    if (n6 == 2 && !rd_in)             bad6 = 1'b1;
    if (c6 == 6'b111000 && rd_in)      bad6 = 1'b1;
    if (c6 == 6'b000111 && !rd_in)     bad6 = 1'b1;
    rd_mid = rd_after6(c6, rd_in);

    // 4-bit sub-block: control symbols only allow y = 0..3 (R6)
    if (k) begin
      if (!c6[5]) begin
        unique case (c4)
          4'b0100: y = 3'd0;
          4'b1001: y = 3'd1;
          4'b0101: y = 3'd2;
          4'b0011: y = 3'd3;
          default: bad4 = 1'b1;
        endcase
      end else begin
        unique case (c4)
          4'b1011: y = 3'd0;
          4'b0110: y = 3'd1;
          4'b1010: y = 3'd2;
          4'b1100: y = 3'd3;
          default: bad4 = 1'b1;
        endcase
      end
    end else begin
      unique case (c4)
        4'b1011, 4'b0100:                   y = 3'd0;
        4'b1001:                            y = 3'd1;
        4'b0101:                            y = 3'd2;
        4'b1100, 4'b0011:                   y = 3'd3;
        4'b1101, 4'b0010:                   y = 3'd4;
        4'b1010:                            y = 3'd5;
        4'b0110:                            y = 3'd6;
        4'b1110, 4'b0001, 4'b0111, 4'b1000: y = 3'd7;
        default:                            bad4 = 1'b1;
      endcase
    end

    // 4-bit disparity rules (R7)
    if (n4 == 3 && rd_mid)             bad4 = 1'b1;
    if (n4 == 1 && !rd_mid)            bad4 = 1'b1;
    if (c4 == 4'b1100 && rd_mid)       bad4 = 1'b1;
    if (c4 == 4'b0011 && !rd_mid)      bad4 = 1'b1;

    rd_out   = rd_after4(c4, rd_mid);
    res.val  = {y, x};
    res.is_k = k;
    res.bad  = bad6 | bad4;
  end

endmodule

// File: rtl/vlink_word_dec.sv
`timescale 1ns/1ps
// Decodes all lanes of a word in one cycle and registers the verdict.
module vlink_word_dec
  import vlink_rx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [LANES*SYM_W-1:0]  word,
  output logic                    s1_valid,
  output logic                    s1_err,
  output logic                    s1_ctrl,
  output logic [LANES*BYTE_W-1:0] s1_pix,
  output logic                    s1_hs,
  output logic                    s1_vs
);

  logic [LANES:0]          rd_c;
  logic                    rd_q;
  sym_res_t                res [LANES];
  logic [LANES*BYTE_W-1:0] pix;
  logic                    any_bad, all_k, any_k, err;

  assign rd_c[0] = rd_q;

  // Lane 0 sits in the top bits and is first in the disparity chain (R2)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vlink_sym_dec u_dec (
      .sym    (word[(LANES-i)*SYM_W-1 -: SYM_W]),
      .rd_in  (rd_c[i]),
      .res    (res[i]),
      .rd_out (rd_c[i+1])
    );
  end

  always_comb begin
    any_bad = 1'b0;
    all_k   = 1'b1;
    any_k   = 1'b0;
    pix     = '0;
    for (int i = 0; i < LANES; i++) begin
      any_bad = any_bad | res[i].bad;
      all_k   = all_k & res[i].is_k;
      any_k   = any_k | res[i].is_k;
      pix[(LANES-i)*BYTE_W-1 -: BYTE_W] = res[i].val;
    end
    // mixed control/data words are rejected (R6)
    err = any_bad | (any_k & ~all_k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;  // negative disparity after reset (R7)
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
      s1_ctrl  <= 1'b0;
      s1_pix   <= '0;
      s1_hs    <= 1'b0;
      s1_vs    <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        rd_q    <= rd_c[LANES];
        s1_err  <= err;
        s1_ctrl <= all_k;
        s1_pix  <= pix;
        s1_hs   <= res[0].val[5];  // K28.y, y bit 0 (R4)
        s1_vs   <= res[0].val[6];  // K28.y, y bit 1 (R4)
      end
    end
  end

endmodule

// File: rtl/vlink_link_mon.sv
`timescale 1ns/1ps
// Link status: drop on a bad word, raise after a run of clean words (R8).
module vlink_link_mon #(
  parameter int GOOD_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s1_valid,
  input  logic s1_err,
  output logic link_ok
);

  localparam int RW = $clog2(GOOD_RUN + 1);
  localparam logic [RW-1:0] RUN_SAT  = RW'(GOOD_RUN);
  localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUN - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      link_ok <= 1'b0;
    end else if (s1_valid) begin
      if (s1_err) begin
        run_q   <= '0;
        link_ok <= 1'b0;
      end else begin
        if (run_q != RUN_SAT) run_q <= run_q + 1'b1;
        if (run_q >= RUN_LAST) link_ok <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vlink_pix_out.sv
`timescale 1ns/1ps
// Output registers: pixel hold, data enable, sync state and polarity.
module vlink_pix_out #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic             s1_err,
  input  logic             s1_ctrl,
  input  logic [PIX_W-1:0] s1_pix,
  input  logic             s1_hs,
  input  logic             s1_vs,
  input  logic             hsync_pol,
  input  logic             vsync_pol,
  output logic [PIX_W-1:0] rgb_out,
  output logic             de_out,
  output logic             hsync_out,
  output logic             vsync_out
);

  logic hs_act_q, vs_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_out  <= '0;
      de_out   <= 1'b0;
      hs_act_q <= 1'b0;
      vs_act_q <= 1'b0;
    end else if (s1_valid && !s1_err) begin
      if (s1_ctrl) begin
        de_out   <= 1'b0;        // blanking: rgb held (R4)
        hs_act_q <= s1_hs;
        vs_act_q <= s1_vs;
      end else begin
        de_out  <= 1'b1;         // pixel (R3)
        rgb_out <= s1_pix;
      end
    end
  end

  // static straps invert the registered sync state (R5)
  assign hsync_out = hs_act_q ^ hsync_pol;
  assign vsync_out = vs_act_q ^ vsync_pol;

endmodule

// File: rtl/vlink_rx_out.sv
`timescale 1ns/1ps
module vlink_rx_out
  import vlink_rx_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int GOOD_RUN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*SYM_W-1:0]  in_word,
  input  logic                    hsync_pol,
  input  logic                    vsync_pol,
  output logic [LANES*BYTE_W-1:0] rgb_out,
  output logic                    hsync_out,
  output logic                    vsync_out,
  output logic                    de_out,
  output logic                    link_ok
);

  localparam int PIX_W = LANES * BYTE_W;

  logic             accept;
  logic             s1_valid, s1_err, s1_ctrl, s1_hs, s1_vs;
  logic [PIX_W-1:0] s1_pix;

  // never stalls once out of reset (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign accept = in_valid & in_ready;

  vlink_word_dec #(.LANES(LANES)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .word     (in_word),
    .s1_valid (s1_valid),
    .s1_err   (s1_err),
    .s1_ctrl  (s1_ctrl),
    .s1_pix   (s1_pix),
    .s1_hs    (s1_hs),
    .s1_vs    (s1_vs)
  );

  vlink_pix_out #(.PIX_W(PIX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_err    (s1_err),
    .s1_ctrl   (s1_ctrl),
    .s1_pix    (s1_pix),
    .s1_hs     (s1_hs),
    .s1_vs     (s1_vs),
    .hsync_pol (hsync_pol),
    .vsync_pol (vsync_pol),
    .rgb_out   (rgb_out),
    .de_out    (de_out),
    .hsync_out (hsync_out),
    .vsync_out (vsync_out)
  );

  vlink_link_mon #(.GOOD_RUN(GOOD_RUN)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_err   (s1_err),
    .link_ok  (link_ok)
  );

endmodule

// File: rtl/vlink_rx_out_chk.sv
`timescale 1ns/1ps
module vlink_rx_out_chk #(
  parameter int PIX_W    = 24,
  parameter int GOOD_RUN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             s1_valid,
  input logic             s1_err,
  input logic             s1_ctrl,
  input logic [PIX_W-1:0] rgb_out,
  input logic             de_out,
  input logic             link_ok
);

  int run_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_c <= 0;
    else if (s1_valid) begin
      if (s1_err)                run_c <= 0;
      else if (run_c < GOOD_RUN) run_c <= run_c + 1;
    end
  end

  // R1: ready never drops once raised
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R4: while blanking, pixel data is frozen
  a_r4_rgb_held: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> $stable(rgb_out));

  // R8: status rises only after enough clean words
  a_r8_rise_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> run_c >= GOOD_RUN);

  // R8: a bad word clears status
  a_r8_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_err) |=> !link_ok);

  // R9: no decoded word, no output change
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(rgb_out) && $stable(de_out) && $stable(link_ok)));

  // R3: a clean word sets data enable from its kind
  a_r3_de_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_err) |=> (de_out == !$past(s1_ctrl)));

endmodule

bind vlink_rx_out vlink_rx_out_chk #(.PIX_W(LANES*8), .GOOD_RUN(GOOD_RUN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .s1_valid (s1_valid),
  .s1_err   (s1_err),
  .s1_ctrl  (s1_ctrl),
  .rgb_out  (rgb_out),
  .de_out   (de_out),
  .link_ok  (link_ok)
);

// File: tb/vlink_rx_out_tb_top.sv
`timescale 1ns/1ps
module vlink_rx_out_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [29:0] in_word = '0;
  logic        hsync_pol = 1'b1;
  logic        vsync_pol = 1'b0;
  logic [23:0] rgb_out;
  logic        hsync_out, vsync_out, de_out, link_ok;

  always #2.5 clk = ~clk;

  vlink_rx_out dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .hsync_pol(hsync_pol), .vsync_pol(vsync_pol),
    .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .de_out(de_out), .link_ok(link_ok)
  );

  int   checks = 0, fails = 0;
  bit   done = 0;
  logic rd_b = 1'b0;  // bench disparity, 1 = positive
  logic [23:0] exp_rgb = '0;
  logic exp_de = 0, exp_hs = 0, exp_vs = 0, exp_ok = 0;
  int   run_b = 0;

  // kind: 0 pixel, 1 control, 2 bad word
  localparam logic [26:0] VEC [12] = '{
    {3'd1, 24'h000000}, {3'd1, 24'h000001}, {3'd1, 24'h000003},
    {3'd0, 24'h123456}, {3'd0, 24'hFF00A5}, {3'd1, 24'h000000},
    {3'd0, 24'h07F1EE}, {3'd2, 24'h5A0033}, {3'd1, 24'h000002},
    {3'd0, 24'h000000}, {3'd0, 24'hFFFFFF}, {3'd0, 24'h1C3CBC}
  };

  function automatic logic [5:0] t6(input logic [4:0] x);
    case (x)
      5'd0: t6 = 6'b100111;  5'd1: t6 = 6'b011101;  5'd2: t6 = 6'b101101;
      5'd3: t6 = 6'b110001;  5'd4: t6 = 6'b110101;  5'd5: t6 = 6'b101001;
      5'd6: t6 = 6'b011001;  5'd7: t6 = 6'b111000;  5'd8: t6 = 6'b111001;
      5'd9: t6 = 6'b100101;  5'd10: t6 = 6'b010101; 5'd11: t6 = 6'b110100;
      5'd12: t6 = 6'b001101; 5'd13: t6 = 6'b101100; 5'd14: t6 = 6'b011100;
      5'd15: t6 = 6'b010111; 5'd16: t6 = 6'b011011; 5'd17: t6 = 6'b100011;
      5'd18: t6 = 6'b010011; 5'd19: t6 = 6'b110010; 5'd20: t6 = 6'b001011;
      5'd21: t6 = 6'b101010; 5'd22: t6 = 6'b011010; 5'd23: t6 = 6'b111010;
      5'd24: t6 = 6'b110011; 5'd25: t6 = 6'b100110; 5'd26: t6 = 6'b010110;
      5'd27: t6 = 6'b110110; 5'd28: t6 = 6'b001110; 5'd29: t6 = 6'b101110;
      5'd30: t6 = 6'b011110; default: t6 = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] t4(input logic [2:0] y);
    case (y)
      3'd0: t4 = 4'b1011; 3'd1: t4 = 4'b1001; 3'd2: t4 = 4'b0101;
      3'd3: t4 = 4'b1100; 3'd4: t4 = 4'b1101; 3'd5: t4 = 4'b1010;
      3'd6: t4 = 4'b0110; default: t4 = 4'b1110;
    endcase
  endfunction

  function automatic logic nrd6(input logic [5:0] c, input logic rd);
    if ($countones(c) > 3 || c == 6'b000111) return 1'b1;
    if ($countones(c) < 3 || c == 6'b111000) return 1'b0;
    return rd;
  endfunction

  function automatic logic nrd4(input logic [3:0] c, input logic rd);
    if ($countones(c) > 2 || c == 4'b0011) return 1'b1;
    if ($countones(c) < 2 || c == 4'b1100) return 1'b0;
    return rd;
  endfunction

  function automatic logic nrd(input logic [9:0] s, input logic rd);
    return nrd4(s[3:0], nrd6(s[9:4], rd));
  endfunction

  function automatic logic [9:0] enc(input logic [7:0] v, input logic rd);
    logic [5:0] c6; logic [3:0] c4; logic r1;
    c6 = t6(v[4:0]);
    if (rd && ($countones(c6) != 3 || c6 == 6'b111000)) c6 = ~c6;
    r1 = nrd6(c6, rd);
    c4 = t4(v[7:5]);
    if (r1 && ($countones(c4) != 2 || c4 == 4'b1100)) c4 = ~c4;
    return {c6, c4};
  endfunction

  function automatic logic [9:0] enc_k(input logic [2:0] y, input logic rd);
    logic [3:0] f;
    case (y)
      3'd0: f = 4'b0100; 3'd1: f = 4'b1001; 3'd2: f = 4'b0101;
      3'd3: f = 4'b0011; 3'd4: f = 4'b0010; 3'd5: f = 4'b1010;
      3'd6: f = 4'b0110; default: f = 4'b1000;
    endcase
    return rd ? ~{6'b001111, f} : {6'b001111, f};
  endfunction

  // Appends one symbol to a word, keeping the bench disparity in step
  task automatic put(inout logic [29:0] w, input int lane, input logic [9:0] s);
    w[29-10*lane -: 10] = s;
    rd_b = nrd(s, rd_b);
  endtask

  task automatic build(input logic [2:0] kind, input logic [23:0] pl, output logic [29:0] w);
    w = '0;
    for (int i = 0; i < 3; i++) begin
      if (kind == 3'd1)                put(w, i, enc_k({1'b0, pl[1:0]}, rd_b));
      else if (kind == 3'd2 && i == 1) put(w, i, 10'h3FF);
      else                             put(w, i, enc(pl[23-8*i -: 8], rd_b));
    end
  endtask

  task automatic model(input logic [2:0] kind, input logic [23:0] pl);
    if (kind == 3'd0) begin exp_de = 1; exp_rgb = pl; end
    if (kind == 3'd1) begin exp_de = 0; exp_hs = pl[0]; exp_vs = pl[1]; end
    if (kind == 3'd2) run_b = 0; else run_b++;
    exp_ok = (run_b >= 4);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " rgb"}, {8'h0, rgb_out}, {8'h0, exp_rgb});
    chk({tag, " de"}, {31'h0, de_out}, {31'h0, exp_de});
    chk("R5 hsync", {31'h0, hsync_out}, {31'h0, exp_hs ^ hsync_pol});
    chk("R5 vsync", {31'h0, vsync_out}, {31'h0, exp_vs ^ vsync_pol});
    chk("R8 link_ok", {31'h0, link_ok}, {31'h0, exp_ok});
  endtask

  task automatic push(input logic [29:0] w);
    @(negedge clk); in_word = w; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [29:0] w;
    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    chk("R1 ready in reset", {31'h0, in_ready}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 ready", {31'h0, in_ready}, 32'h1);
    check_all("R1");

    // table walk: R2 R3 R4 R6
    foreach (VEC[i]) begin
      build(VEC[i][26:24], VEC[i][23:0], w);
      push(w);
      model(VEC[i][26:24], VEC[i][23:0]);
      case (VEC[i][26:24])
        3'd0:    check_all("R2 R3");
        3'd1:    check_all("R4");
        default: check_all("R6");
      endcase
    end

    // R9: latency of two edges
    build(3'd0, 24'hA1B2C3, w);
    @(negedge clk); in_word = w; in_valid = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    chk("R9 one edge", {8'h0, rgb_out}, {8'h0, exp_rgb});
    @(posedge clk); @(negedge clk);
    model(3'd0, 24'hA1B2C3);
    check_all("R9");

    // R9: idle cycles change nothing
    repeat (8) @(negedge clk);
    check_all("R9 idle");
    chk("R1 ready held", {31'h0, in_ready}, 32'h1);

    // R7: lane 0 in the form for the opposite disparity
    w = '0;
    put(w, 0, enc(8'h00, ~rd_b));
    put(w, 1, enc(8'h11, rd_b));
    put(w, 2, enc(8'h22, rd_b));
    push(w); model(3'd2, '0);
    check_all("R7 breach");

    // R6: K28.5 is not an accepted control symbol
    w = '0;
    for (int i = 0; i < 3; i++) put(w, i, enc_k(3'd5, rd_b));
    push(w); model(3'd2, '0);
    check_all("R6 k28.5");

    // R6: mixed control and data
    w = '0;
    put(w, 0, enc_k(3'd3, rd_b));
    put(w, 1, enc(8'h44, rd_b));
    put(w, 2, enc(8'h55, rd_b));
    push(w); model(3'd2, '0);
    check_all("R6 mixed");

    // R8 and R7: three clean words keep status low, the fourth raises it
    for (int n = 0; n < 4; n++) begin
      build(3'd0, 24'h3C5A00 + 24'(n), w);
      push(w); model(3'd0, 24'h3C5A00 + 24'(n));
      check_all("R8 recover");
    end

    // R5: strap flip inverts the pins
    build(3'd1, 24'h000001, w);
    push(w); model(3'd1, 24'h000001);
    hsync_pol = 1'b0; vsync_pol = 1'b1;
    @(negedge clk);
    check_all("R5 straps");

    done = 1;
    summary();
    $finish;
  end

endmodule